// File: doc/BRIEF.md
# Serial Byte Receiver with Break-Suppressing Receive Queue

This block recovers bytes from an asynchronous serial line (one start bit, eight data bits sent least significant bit first, one stop bit) using a fixed 16x oversampling clock. Each recovered byte is placed in a 16-entry receive queue. A framing-error tag, set when the stop bit is sampled low, travels with each byte. Software reads bytes and status through a small register port. A queue level output lets the surrounding logic see how many bytes are waiting.

The framing-error status tracks the queue head, not the most recent frame. Its value therefore always describes the byte that the next data read will return. A line held at space is handled as follows. The first bad frame enters the queue normally. If a further all-zero frame with a low stop bit follows without the line rising in between, a sticky break flag is raised. That zero byte is dropped, and reception stays suspended until the line returns to mark. The next valid start bit after that is received normally.

When the queue is full, a completed frame is thrown away and a sticky overrun flag is raised. The break flag and the overrun flag are each cleared only by a read that returns the flag as 1, followed by a write of 0 to that flag's position.

Top module: `uart_brk_rx`

## Requirements
- R1: A frame whose stop bit samples high is pushed with its eight data bits in order of arrival, least significant bit first. It carries framing tag 0. A read at address 0 returns the head byte and removes it, so bytes come out in arrival order.
- R2: A frame whose stop bit samples low is pushed with framing tag 1. Status bit 2 (address 1) always shows the tag of the current head entry. It changes as entries are popped and reads 0 when the queue is empty.
- R3: A low pulse on the line that has ended before the midpoint of a start bit is discarded. It adds no entry.
- R4: After a framing-error frame, a second all-zero frame with a low stop bit that arrives with no mark in between sets the break flag (status bit 0). That byte is not pushed, and nothing is pushed while the line stays low.
- R5: Once the line returns to mark after a break, the next valid frame is received and pushed normally.
- R6: The break flag clears only when a status read returns it as 1 and the next status write (address 1) carries 0 in bit 0. A write of 0 with no such read leaves it set. A write of 1 leaves it set.
- R7: A frame that completes while the queue holds 16 entries is discarded, and the overrun flag (status bit 1) is set. The overrun flag is cleared by the same read-1-then-write-0 rule, using write bit 1. Status bit 4 shows full.
- R8: A data read while the queue is empty returns 0x00 and leaves the level unchanged. Status bit 3 shows empty.
- R9: After reset, the level is 0 and the status byte reads 0x08 (only empty set).
- R10: The level output equals the number of stored entries. A push and a pop in the same cycle leave it unchanged and keep the queue order intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| reg_addr | input | 2 | Register select: 0 data, 1 status |
| reg_rd | input | 1 | Read strobe; read data appears on the next cycle |
| reg_wr | input | 1 | Write strobe (status register only) |
| reg_wdata | input | 2 | Write data: bit 0 break flag, bit 1 overrun flag |
| reg_rdata | output | 8 | Registered read data |
| fifo_level | output | 5 | Number of entries in the receive queue |

## Verification
A frame completing and a data read can fall in the same clock cycle. In that cycle the queue is written and popped at once. The bench holds one known byte in the queue and sends a new frame. It issues a single data read at an offset that steps across twenty consecutive cycles around the stop-bit sample, so one of these reads lands exactly on the push. Each attempt is judged by three results: the read must return the old byte, the level must settle at 1, and the new byte must be the next one out.

// File: rtl/uabr_pkg.sv
package uabr_pkg;
  localparam int DATA_W = 8;

  // status byte layout
  localparam int ST_BRK   = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_FERR  = 2;
  localparam int ST_EMPTY = 3;
  localparam int ST_FULL  = 4;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;

  typedef struct packed {
    logic              ferr;
    logic [DATA_W-1:0] data;
  } rx_ent_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD
  } rx_state_t;
endpackage

// File: rtl/uabr_rx.sv
module uabr_rx
  import uabr_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int TICK_DIV = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  output logic              frm_vld,
  output logic [DATA_W-1:0] frm_data,
  output logic              frm_ferr,
  output logic              brk_evt
);
  localparam int OSR_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;
  localparam int BIT_W = $clog2(DATA_W);

  logic rx_m, rx_s, tick, pend;
  rx_state_t state;
  logic [OSR_W-1:0]  os_cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_cnt;
      always_ff @(posedge clk) begin
        if (rst || div_cnt == DW'(TICK_DIV - 1)) div_cnt <= '0;
        else                                     div_cnt <= div_cnt + 1'b1;
      end
      assign tick = (div_cnt == DW'(TICK_DIV - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      os_cnt   <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      pend     <= 1'b0;
      frm_vld  <= 1'b0;
      frm_ferr <= 1'b0;
      frm_data <= '0;
      brk_evt  <= 1'b0;
    end else begin
      frm_vld <= 1'b0;
      brk_evt <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (rx_s) pend <= 1'b0;
          if (tick && !rx_s) begin
            state  <= RX_START;
            os_cnt <= '0;
          end
        end
        RX_START: if (tick) begin
          if (os_cnt == OSR_W'(HALF - 1)) begin
            os_cnt  <= '0;
            bit_idx <= '0;
            state   <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (os_cnt == OSR_W'(OSR - 1)) begin
            os_cnt <= '0;
            shreg  <= {rx_s, shreg[DATA_W-1:1]};
            if (bit_idx == BIT_W'(DATA_W - 1)) state <= RX_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (os_cnt == OSR_W'(OSR - 1)) begin
            os_cnt   <= '0;
            frm_data <= shreg;
            if (rx_s) begin
              state    <= RX_IDLE;
              frm_vld  <= 1'b1;
              frm_ferr <= 1'b0;
              pend     <= 1'b0;
            end else if (pend && shreg == '0) begin
              state   <= RX_HOLD;
              brk_evt <= 1'b1;
              pend    <= 1'b0;
            end else begin
              state    <= RX_IDLE;
              frm_vld  <= 1'b1;
              frm_ferr <= 1'b1;
              pend     <= 1'b1;
            end
          end else begin
            os_cnt <= os_cnt + 1'b1;
          end
        end
        RX_HOLD: if (rx_s) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  assert_hold_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (state == RX_HOLD) |-> !frm_vld);
  assert_brk_not_pushed_R4: assert property (@(posedge clk) disable iff (rst)
    brk_evt |-> !frm_vld);
endmodule

// File: rtl/uabr_fifo.sv
module uabr_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     head,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_wr, do_rd;

  assign empty = (level == '0);
  assign full  = (level == LVL_W'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
  assert_level_up_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !full && !(rd_en && !empty)) |=> (level == $past(level) + 1'b1));
  assert_level_same_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && !empty && !full) |=> (level == $past(level)));
  assert_empty_read_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !wr_en) |=> (level == '0));
endmodule

// File: rtl/uabr_status.sv
module uabr_status #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_evt,
  input  logic             st_rd,
  input  logic             st_wr,
  input  logic [NFLAG-1:0] st_wdata,
  output logic [NFLAG-1:0] flag
);
  logic [NFLAG-1:0] arm;

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) begin
          flag[i] <= 1'b0;
          arm[i]  <= 1'b0;
        end else begin
          if (set_evt[i])                          flag[i] <= 1'b1;
          else if (st_wr && arm[i] && !st_wdata[i]) flag[i] <= 1'b0;
          if (st_wr)                    arm[i] <= 1'b0;
          else if (st_rd && flag[i])    arm[i] <= 1'b1;
        end
      end

      assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        set_evt[i] |=> flag[i]);
      assert_no_blind_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (flag[i] && !arm[i]) |=> flag[i]);
      assert_arm_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
        arm[i] |-> flag[i]);
    end
  endgenerate
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import uabr_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int TICK_DIV = 1,
  parameter int DEPTH    = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rxd,
  input  logic [1:0]                   reg_addr,
  input  logic                         reg_rd,
  input  logic                         reg_wr,
  input  logic [1:0]                   reg_wdata,
  output logic [7:0]                   reg_rdata,
  output logic [$clog2(DEPTH+1)-1:0]   fifo_level
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic              frm_vld, frm_ferr, brk_evt;
  logic [DATA_W-1:0] frm_data;
  rx_ent_t           head, wr_ent;
  logic              empty, full, push, pop, ovr_evt;
  logic [1:0]        flags;
  logic [7:0]        stat;

  uabr_rx #(.OSR(OSR), .TICK_DIV(TICK_DIV)) rx_i (
    .clk(clk), .rst(rst), .rxd(rxd),
    .frm_vld(frm_vld), .frm_data(frm_data), .frm_ferr(frm_ferr),
    .brk_evt(brk_evt)
  );

  assign push    = frm_vld && !full;
  assign ovr_evt = frm_vld && full;
  assign pop     = reg_rd && (reg_addr == A_DATA);
  assign wr_ent  = '{ferr: frm_ferr, data: frm_data};

  uabr_fifo #(.W($bits(rx_ent_t)), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst),
    .wr_en(push), .wr_data(wr_ent),
    .rd_en(pop), .head(head),
    .empty(empty), .full(full), .level(fifo_level)
  );

  uabr_status #(.NFLAG(2)) stat_i (
    .clk(clk), .rst(rst),
    .set_evt({ovr_evt, brk_evt}),
    .st_rd(reg_rd && reg_addr == A_STAT),
    .st_wr(reg_wr && reg_addr == A_STAT),
    .st_wdata(reg_wdata),
    .flag(flags)
  );

  always_comb begin
    stat           = '0;
    stat[ST_BRK]   = flags[0];
    stat[ST_OVR]   = flags[1];
    stat[ST_FERR]  = !empty && head.ferr;
    stat[ST_EMPTY] = empty;
    stat[ST_FULL]  = full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_DATA:  reg_rdata <= empty ? 8'h00 : head.data;
        A_STAT:  reg_rdata <= stat;
        default: reg_rdata <= 8'h00;
      endcase
    end
  end

  assert_ovr_flag_R7: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> flags[1]);
  assert_level_bound_R10: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LVL_W'(DEPTH));
endmodule

// File: tb/uart_brk_rx_tb.sv
`timescale 1ns/1ps
module uart_brk_rx_tb_top;
  localparam int OSR = 16, DIV = 1, DEPTH = 16, BIT = OSR * DIV;

  logic clk = 1'b0, rst = 1'b1, rxd = 1'b1;
  logic [1:0] reg_addr = '0, reg_wdata = '0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_rdata;
  logic [4:0] fifo_level;

  int n_chk = 0, n_bad = 0;
  logic [8:0] exp_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  uart_brk_rx #(.OSR(OSR), .TICK_DIV(DIV), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .rxd(rxd), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fifo_level(fifo_level)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic reg_write(input logic [1:0] d);
    @(negedge clk); reg_addr = 2'd1; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wait_bits(input int n);
    repeat (n * BIT) @(negedge clk);
  endtask

  // driver: serialises a frame and records what the queue should hold
  task automatic send_frame(input logic [7:0] d, input bit stop, input bit keep);
    if (keep) exp_q.push_back({~stop, d});
    @(negedge clk); rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
  endtask

  // monitor side: pops one expected entry and compares tag and byte
  task automatic pop_check(input string req);
    logic [7:0] s, d;
    logic [8:0] e;
    e = exp_q.pop_front();
    reg_read(2'd1, s);
    check(s[2] == e[8], "R2", "head framing tag", s[2], e[8]);
    reg_read(2'd0, d);
    check(d == e[7:0], req, "data byte", d, e[7:0]);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] s, d;
    logic [4:0] lvl0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    check(fifo_level == 0, "R9", "level after reset", fifo_level, 0);
    reg_read(2'd1, s);
    check(s == 8'h08, "R9", "status after reset", s, 8'h08);

    // R1 plain frames, several patterns
    send_frame(8'hA5, 1, 1); send_frame(8'h3C, 1, 1);
    send_frame(8'hFF, 1, 1); send_frame(8'h00, 1, 1);
    wait_bits(2);
    check(fifo_level == 4, "R10", "level after four frames", fifo_level, 4);
    repeat (4) pop_check("R1");

    // R2 head-tracking framing tag
    send_frame(8'h11, 1, 1); send_frame(8'h33, 0, 1);
    wait_bits(3);
    pop_check("R2"); pop_check("R2");
    reg_read(2'd1, s);
    check(s[2] == 1'b0, "R2", "tag when empty", s[2], 0);

    // R3 short glitch
    lvl0 = fifo_level;
    @(negedge clk); rxd = 1'b0;
    repeat (5) @(negedge clk); rxd = 1'b1;
    wait_bits(3);
    check(fifo_level == lvl0, "R3", "level after glitch", fifo_level, lvl0);
    send_frame(8'h96, 1, 1);
    wait_bits(2);
    pop_check("R3");

    // R8 empty read
    reg_read(2'd0, d);
    check(d == 8'h00, "R8", "empty data read", d, 0);
    check(fifo_level == 0, "R8", "level after empty read", fifo_level, 0);

    // R4 break: first bad frame kept, the zero run suppressed
    send_frame(8'h00, 0, 1);
    rxd = 1'b0;
    wait_bits(30);
    check(fifo_level == 1, "R4", "level during break", fifo_level, 1);
    reg_read(2'd1, s);
    check(s[0] == 1'b1, "R4", "break flag", s[0], 1);
    rxd = 1'b1;
    wait_bits(2);
    // R5 resume
    send_frame(8'h5A, 1, 1);
    wait_bits(2);
    check(fifo_level == 2, "R5", "level after resume", fifo_level, 2);
    pop_check("R4"); pop_check("R5");

    // R6 clear protocol
    reg_write(2'b11);
    reg_write(2'b00);
    reg_read(2'd1, s);
    check(s[0] == 1'b1, "R6", "break after write0 without read", s[0], 1);
    reg_write(2'b11);
    reg_read(2'd1, s);
    check(s[0] == 1'b1, "R6", "break after write1", s[0], 1);
    reg_write(2'b00);
    reg_read(2'd1, s);
    check(s[0] == 1'b0, "R6", "break after read1 write0", s[0], 0);

    // R7 overrun
    for (int i = 0; i < DEPTH + 1; i++)
      send_frame(8'(i * 7 + 1), 1, (i < DEPTH));
    wait_bits(2);
    check(fifo_level == DEPTH, "R7", "level when full", fifo_level, DEPTH);
    reg_read(2'd1, s);
    check(s[1] == 1'b1, "R7", "overrun flag", s[1], 1);
    check(s[4] == 1'b1, "R7", "full flag", s[4], 1);
    repeat (DEPTH) pop_check("R7");
    reg_read(2'd1, s);
    check(s[1] == 1'b1, "R7", "overrun sticky", s[1], 1);
    reg_write(2'b00);
    reg_read(2'd1, s);
    check(s[1] == 1'b0, "R7", "overrun cleared", s[1], 0);
    check(s[3] == 1'b1, "R8", "empty flag", s[3], 1);

    // R10 push and pop landing together
    send_frame(8'h42, 1, 1);
    wait_bits(2);
    for (int k = 0; k < 20; k++) begin
      fork
        send_frame(8'(8'h80 + k), 1, 1);
        begin
          logic [7:0] rd;
          logic [8:0] e;
          repeat (BIT * 9 + k) @(negedge clk);
          e = exp_q.pop_front();
          reg_read(2'd0, rd);
          check(rd == e[7:0], "R10", "old byte on coincident read", rd, e[7:0]);
        end
      join
      wait_bits(2);
      check(fifo_level == 1, "R10", "level after push+pop", fifo_level, 1);
    end
    pop_check("R10");

    done = 1;
    finish_run();
  end
endmodule